// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs PHY management transactions over a two-wire MDC/MDIO link. It is built around one 32-bit word that the host writes to start a transaction. The engine first sends a 32-bit run of ones as a preamble. It then rotates the word out most significant bit first and, on the same rotation, takes a bit in at the least significant end.

The host can read the word at any time. While a frame is running it sees the partly rotated contents. After the last bit time every bit is back where it started. For a read frame, the low 18 positions (turnaround plus data) then hold whatever the PHY drove.

MDC is made from the system clock by a divider that the host sets. The host picks the frame type, clause 22 or clause 45, through the start and opcode bits it writes. A level status output shows that the engine is idle, and an interrupt pulse marks the end of each frame.

Top module: `mdio_shift_master`

## Requirements
- R1: A write (`wr_en` high) while idle loads `wr_data` into the word and starts a frame. On the next cycle `mgmt_idle` is low and `rd_data` equals the written value.
- R2: While a frame runs, MDC is low for `div_half`+1 clocks and then high for `div_half`+1 clocks in each bit time, starting low. While idle, MDC is low and `mdio_oe` is low.
- R3: The first 32 bit times of a frame drive a one on `mdio_o` with `mdio_oe` high.
- R4: Bit times 32 to 63 drive the word's bit 31 at that moment, so the written word goes out MSB first. `mdio_o` changes only while MDC is low, and it is stable at each MDC rising edge.
- R5: A frame is a read frame when bit 29 of the written word is 1. A read frame releases `mdio_oe` for the last 18 bit times (word bits 17..0). In those bit times, the bit entering the LSB is the `mdio_i` value sampled on the MDC rising edge.
- R6: `rd_data` always shows the live word. Starting with bit time 32, it rotates left by one at each MDC falling edge and does not change at any other time.
- R7: At the end of a frame, for a write frame (bit 29 = 0), `rd_data` equals the written word. For a read frame, `rd_data` holds the written bits 31..18, and bits 17..0 hold the sampled PHY bits, first received in bit 17.
- R8: The MDC falling edge that ends bit time 63 sets `mgmt_idle` and raises `mgmt_irq` for exactly one clock.
- R9: The written value alone selects the frame type. Clause 45 frames (bits 31..30 = 00) are handled with the same rules: address and write operations (bit 29 = 0) come back unchanged, and read and read-increment operations (bit 29 = 1) merge PHY data.
- R10: A write while a frame is running is ignored. The running frame and its final word are unaffected.
- R11: After reset `mgmt_idle` is 1, and `mgmt_irq`, `mdc`, `mdio_oe` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_half | input | DIV_W | MDC half period in clocks minus one, held stable during a frame |
| wr_en | input | 1 | Host write strobe for the management word |
| wr_data | input | 32 | Management word to load |
| rd_data | output | 32 | Live contents of the management word |
| mgmt_idle | output | 1 | High when no frame is running (completion status) |
| mgmt_irq | output | 1 | One-clock pulse when a frame completes |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The engine is tried with clause 22 write and read words, clause 45 address, write, read and read-increment words, and divider settings 0, 1 and 3.

Write-type words show that the rotation brings every bit home. Read-type words with distinct PHY responses show that only the low 18 positions take line data, and in the right order. Changing the divider separates a correct phase count from an off-by-one in the MDC timing. A second write issued in the middle of a frame tells a locked word apart from one that reloads.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int MDIO_WORD_W   = 32;
    localparam int MDIO_PRE_LEN  = 32;
    localparam int MDIO_RESP_W   = 18;
    localparam int MDIO_RD_BIT   = 29;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_PREAMBLE = 2'd1,
        PH_BODY     = 2'd2
    } mdio_phase_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t s_d, s_q;
    logic at_end;

    assign at_end    = run && (s_q.cnt == div_half);
    assign rise_tick = at_end && !s_q.mdc;
    assign fall_tick = at_end && s_q.mdc;
    assign mdc       = s_q.mdc;

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d = '0;
        end else if (at_end) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_pkg::*;
#(
    parameter int WORD_W  = MDIO_WORD_W,
    parameter int PRE_LEN = MDIO_PRE_LEN,
    parameter int RESP_W  = MDIO_RESP_W,
    parameter int RD_BIT  = MDIO_RD_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_in,
    output logic              busy,
    output logic [WORD_W-1:0] word,
    output logic              mdio_out,
    output logic              mdio_drive,
    output logic              done_pulse
);
    localparam int MAX_LEN  = (WORD_W > PRE_LEN) ? WORD_W : PRE_LEN;
    localparam int CNT_W    = $clog2(MAX_LEN);
    localparam int TA_FIRST = WORD_W - RESP_W;

    typedef struct packed {
        mdio_phase_e       phase;
        logic [CNT_W-1:0]  bitcnt;
        logic [WORD_W-1:0] shreg;
        logic              samp;
        logic              rd;
        logic              irq;
    } shf_t;

    shf_t s_d, s_q;
    logic released;
    logic in_bit;

    assign released   = s_q.rd && (s_q.phase == PH_BODY) &&
                        (s_q.bitcnt >= CNT_W'(TA_FIRST));
    assign in_bit     = released ? s_q.samp : s_q.shreg[WORD_W-1];
    assign busy       = (s_q.phase != PH_IDLE);
    assign word       = s_q.shreg;
    assign mdio_out   = (s_q.phase == PH_PREAMBLE) ? 1'b1 : s_q.shreg[WORD_W-1];
    assign mdio_drive = busy && !released;
    assign done_pulse = s_q.irq;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (load && !busy) begin
            s_d.phase  = PH_PREAMBLE;
            s_d.bitcnt = '0;
            s_d.shreg  = load_data;
            s_d.rd     = load_data[RD_BIT];
        end else begin
            if (rise_tick) begin
                s_d.samp = mdio_in;
            end
            if (fall_tick) begin
                case (s_q.phase)
                    PH_PREAMBLE: begin
                        if (s_q.bitcnt == CNT_W'(PRE_LEN - 1)) begin
                            s_d.phase  = PH_BODY;
                            s_d.bitcnt = '0;
                        end else begin
                            s_d.bitcnt = s_q.bitcnt + CNT_W'(1);
                        end
                    end
                    PH_BODY: begin
                        s_d.shreg = {s_q.shreg[WORD_W-2:0], in_bit};
                        if (s_q.bitcnt == CNT_W'(WORD_W - 1)) begin
                            s_d.phase = PH_IDLE;
                            s_d.irq   = 1'b1;
                        end else begin
                            s_d.bitcnt = s_q.bitcnt + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/mdio_shift_master.sv
module mdio_shift_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DIV_W-1:0]       div_half,
    input  logic                   wr_en,
    input  logic [MDIO_WORD_W-1:0] wr_data,
    output logic [MDIO_WORD_W-1:0] rd_data,
    output logic                   mgmt_idle,
    output logic                   mgmt_irq,
    output logic                   mdc,
    output logic                   mdio_o,
    output logic                   mdio_oe,
    input  logic                   mdio_i
);
    logic busy;
    logic rise_tick;
    logic fall_tick;

    mdio_mdc_gen #(.DIV_W(DIV_W)) i_mdc_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div_half  (div_half),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_shifter #(
        .WORD_W  (MDIO_WORD_W),
        .PRE_LEN (MDIO_PRE_LEN),
        .RESP_W  (MDIO_RESP_W),
        .RD_BIT  (MDIO_RD_BIT)
    ) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_en),
        .load_data  (wr_data),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_in    (mdio_i),
        .busy       (busy),
        .word       (rd_data),
        .mdio_out   (mdio_o),
        .mdio_drive (mdio_oe),
        .done_pulse (mgmt_irq)
    );

    assign mgmt_idle = !busy;
endmodule

// File: rtl/mdio_shift_checker.sv
module mdio_shift_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        mgmt_idle,
    input logic        mgmt_irq,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_idle && wr_en) |=> (!mgmt_idle && rd_data == $past(wr_data))); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_idle |-> (!mdc && !mdio_oe)); // R2

    AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4

    AST_WORD_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_idle && !$past(mgmt_idle) && !$fell(mdc)) |-> $stable(rd_data)); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_irq |=> !mgmt_irq); // R8

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_irq |-> (mgmt_idle && !$past(mgmt_idle) && $fell(mdc))); // R8
endmodule

bind mdio_shift_master mdio_shift_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .mgmt_idle (mgmt_idle),
    .mgmt_irq  (mgmt_irq),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio_shift_master.sv
`timescale 1ns/1ps
module test_mdio_shift_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_half = 8'd1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mgmt_idle, mgmt_irq, mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mdio_shift_master #(.DIV_W(8)) i_mdio_shift_master (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .mgmt_idle(mgmt_idle),
        .mgmt_irq(mgmt_irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // PHY model: answers read frames from p_resp, idles high otherwise
    logic [17:0] p_resp = '0;
    logic        phy_drv = 1'b1;
    int          p_idx = 0;
    logic        p_prev_mdc = 1'b0;
    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    always @(negedge clk) begin
        if (mgmt_idle) p_idx = 0;
        else if (p_prev_mdc && !mdc) p_idx++;
        p_prev_mdc = mdc;
        phy_drv = (p_idx >= 46 && p_idx < 64) ? p_resp[63 - p_idx] : 1'b1;
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Behavioural reference model, updated at each rising clock edge
    bit          m_busy = 0;
    bit          m_irq = 0;
    bit          m_rd = 0;
    logic        m_samp = 1'b0;
    logic [31:0] m_reg = '0;
    int          m_t = 0;
    int          m_h = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_irq = 0; m_reg = '0; m_t = 0;
        end else begin
            m_irq = 0;
            if (!m_busy) begin
                if (wr_en) begin
                    m_busy = 1; m_t = 0; m_reg = wr_data;
                    m_rd = wr_data[29]; m_h = int'(div_half) + 1;
                end
            end else begin
                m_t++;
                if (m_t % (2 * m_h) == m_h) m_samp = mdio_i;
                else if (m_t % (2 * m_h) == 0) begin
                    int b;
                    b = m_t / (2 * m_h) - 1;
                    if (b >= 32)
                        m_reg = {m_reg[30:0], (m_rd && b >= 46) ? m_samp : m_reg[31]};
                    if (b == 63) begin m_busy = 0; m_irq = 1; end
                end
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int  cur;
            bit  e_mdc, e_oe;
            cur   = m_t / (2 * m_h);
            e_mdc = m_busy && (m_t % (2 * m_h) >= m_h);
            e_oe  = m_busy && !(m_rd && cur >= 46);
            check(mgmt_idle == !m_busy, "R1 idle status", 32'(mgmt_idle), 32'(!m_busy));
            check(mdc == e_mdc, "R2 mdc phase", 32'(mdc), 32'(e_mdc));
            check(mdio_oe == e_oe, "R5 mdio_oe", 32'(mdio_oe), 32'(e_oe));
            if (e_oe) begin
                if (cur < 32) check(mdio_o == 1'b1, "R3 preamble bit", 32'(mdio_o), 32'd1);
                else          check(mdio_o == m_reg[31], "R4 body bit", 32'(mdio_o), 32'(m_reg[31]));
            end
            check(rd_data == m_reg, "R6 live word", rd_data, m_reg);
            check(mgmt_irq == m_irq, "R8 irq pulse", 32'(mgmt_irq), 32'(m_irq));
        end
    end

    task automatic run_frame(input logic [31:0] w, input logic [17:0] resp, input string tag);
        logic [31:0] exp_final;
        bit saw_irq;
        exp_final = w[29] ? {w[31:18], resp} : w;
        p_resp = resp;
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
        check(!mgmt_idle && rd_data == w, {"R1 load ", tag}, rd_data, w);
        saw_irq = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (mgmt_irq) saw_irq = 1;
            if (mgmt_idle) break;
        end
        check(saw_irq, {"R8 completion irq ", tag}, 32'(saw_irq), 32'd1);
        check(rd_data == exp_final, {"R7 final word ", tag}, rd_data, exp_final);
        @(negedge clk);
        check(!mgmt_irq && mgmt_idle, {"R8 irq cleared ", tag}, 32'(mgmt_irq), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mgmt_idle == 1'b1, "R11 reset idle", 32'(mgmt_idle), 32'd1);
        check(rd_data == 32'd0, "R11 reset word", rd_data, 32'd0);
        check(!mgmt_irq && !mdc && !mdio_oe, "R11 reset outputs",
              {29'd0, mgmt_irq, mdc, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        div_half = 8'd1;
        run_frame(32'h5A3C_9E71, 18'h2BEEF, "c22 write");
        run_frame(32'h6C8A_0000, 18'h2BEEF, "c22 read");

        div_half = 8'd3;
        run_frame(32'h0A46_1234, 18'h21357, "R9 c45 address");
        run_frame(32'h1A46_5678, 18'h21357, "R9 c45 write");
        run_frame(32'h3A4A_0000, 18'h21357, "R9 c45 read");
        run_frame(32'h2B56_0000, 18'h20F0F, "R9 c45 read-increment");

        // R10: a second write in the middle of a frame must be dropped
        div_half = 8'd0;
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h5FFF_0001;
        @(negedge clk); wr_en = 1'b0;
        repeat (90) @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h6123_4567;
        @(negedge clk); wr_en = 1'b0;
        check(!mgmt_idle, "R10 still busy after dropped write", 32'(mgmt_idle), 32'd0);
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (mgmt_idle) break;
        end
        check(rd_data == 32'h5FFF_0001, "R10 busy write ignored", rd_data, 32'h5FFF_0001);

        run_frame(32'h6FFF_0002, 18'h3FFFF, "div0 read");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog R8 frame never completed actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule